// File: doc/BRIEF.md
# Four-Bank SDRAM Command Sequencer

This block sits on the controller side of a single-data-rate SDRAM with four banks. It turns host access requests into the command stream on the memory's control pins: chip select, row strobe, column strobe, write enable, bank select and address. A host request carries a write flag, a bank, a row, a column and an auto-precharge flag. The host holds the request until it sees a grant. The grant is given in the cycle the column command is chosen, and the command appears on the pins one clock later. The data path and read-latency capture are handled elsewhere.

Each bank keeps its own open row and its own timers: activate to column, activate to precharge, activate to activate or refresh, precharge to activate, and data/write recovery. Shared counters space activates across banks, space column bursts, and time the periodic refresh. All nanosecond limits are given as parameters and converted to clock counts by rounding up. After reset the block holds the bus idle for a programmable wait. It then closes all banks, issues two refreshes and loads the mode register before it accepts host traffic.

Top module: `sdram_seq`

## Requirements
- R1: While reset is held, and for at least INIT_CYC clocks after it is released, the pins carry only the idle code {cs_n,ras_n,cas_n,we_n}=0111.
- R2: Before any host command, the start-up runs in this order: precharge-all (code 0010 with addr[10]=1), refresh (0001), a second refresh, then mode load (0000) with addr equal to MODE_WORD.
- R3: A read (0101) or write (0100) goes to a bank only when that bank is open, and at least tRCD clocks after its activate (0011, addr = row).
- R4: On one bank, precharge follows activate by at least tRAS. Activate follows that bank's close by at least tRP. Activate follows the previous activate on that bank, or any refresh, by at least tRC.
- R5: Activates to any two banks are at least tRRD clocks apart.
- R6: An explicit precharge of a bank comes at least BURST_LEN-1+T_WR clocks after its last write and at least BURST_LEN clocks after its last read.
- R7: Every granted request yields exactly one column command, in request order, with the request's bank, column and write flag and with addr[10] equal to the auto-precharge flag. The command reaches the pins on the clock after the grant. Column commands are at least BURST_LEN clocks apart.
- R8: A request whose row is already open in its bank is served with no activate. A request to a bank open on another row first gets a single-bank precharge (addr[10]=0) and then an activate of the new row.
- R9: After a column command with auto-precharge, the bank closes on its own, with no precharge on the pins. This happens at the latest of: read + BURST_LEN, write + BURST_LEN-1+T_WR, and activate + tRAS. The next activate then waits tRP.
- R10: In normal operation a refresh falls due every REF_INTERVAL clocks. Once the current burst ends it is served ahead of host requests: precharge-all if any bank is open, then refresh once every bank is closed. Serviced refreshes are never more than REF_INTERVAL plus a small service slack apart.
- R11: The timing limits are the nanosecond values divided by the clock period and rounded up. At a 10 ns clock this gives tRCD 2, tRAS 5, tRP 2, tRC 6 and tRRD 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present, held until granted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_ap | input | 1 | Close the bank automatically after this access |
| req_grant | output | 1 | Request accepted; its column command is on the pins next clock |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Row, column or mode value; bit 10 selects auto/all precharge |

## Verification
Every cycle, the embedded properties check that per-bank timers have expired when an activate, precharge or column command is chosen, that cross-bank activate spacing holds, that a refresh never meets an open bank, that the bus stays idle in the start-up wait, and that a grant is followed by a column code. Only the bench scenarios can show the ordering of the start-up sequence and the queued matching of granted requests to column commands. The same holds for hit versus miss handling, the exact moment an auto-precharged bank becomes usable again, and the upper bound on refresh spacing while traffic competes for the bus.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    C_MRS = 4'b0000,
    C_REF = 4'b0001,
    C_PRE = 4'b0010,
    C_ACT = 4'b0011,
    C_WR  = 4'b0100,
    C_RD  = 4'b0101,
    C_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PREALL, ST_REF1, ST_REF2, ST_MRS, ST_RUN
  } phase_e;

  // ceiling conversion of a nanosecond limit into clock cycles
  function automatic int ns2clk(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/bank_track.sv
module bank_track #(
  parameter int T_RCD = 2,
  parameter int T_RAS = 5,
  parameter int T_RP  = 2,
  parameter int T_RC  = 6,
  parameter int T_WR  = 2,
  parameter int BL    = 4,
  parameter int ROW_W = 13,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             ref_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             col_ok_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);

  logic             open_q, open_d, ap_q, ap_d, auto_pre;
  logic [ROW_W-1:0] row_q, row_d;
  logic [CW-1:0]    rcd_q, rcd_d, ras_q, ras_d, rc_q, rc_d, rp_q, rp_d, rec_q, rec_d;

  always_comb begin
    auto_pre = ap_q && (rec_q == '0) && (ras_q == '0);
    open_d = open_q;
    row_d  = row_q;
    ap_d   = ap_q;
    rcd_d  = (rcd_q == '0) ? rcd_q : rcd_q - 1'b1;
    ras_d  = (ras_q == '0) ? ras_q : ras_q - 1'b1;
    rc_d   = (rc_q  == '0) ? rc_q  : rc_q  - 1'b1;
    rp_d   = (rp_q  == '0) ? rp_q  : rp_q  - 1'b1;
    rec_d  = (rec_q == '0) ? rec_q : rec_q - 1'b1;
    if (act_i) begin
      open_d = 1'b1;
      row_d  = row_i;
      rcd_d  = CW'(T_RCD - 1);
      ras_d  = CW'(T_RAS - 1);
      rc_d   = CW'(T_RC - 1);
    end
    if (ref_i) rc_d = CW'(T_RC - 1);
    if (col_i) begin
      rec_d = wr_i ? CW'(BL + T_WR - 2) : CW'(BL - 1);
      ap_d  = ap_i;
    end
    if (pre_i || auto_pre) begin
      open_d = 1'b0;
      ap_d   = 1'b0;
      rp_d   = CW'(T_RP - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      rec_q  <= '0;
    end else begin
      open_q <= open_d;
      ap_q   <= ap_d;
      if (act_i) row_q <= row_d;
      rcd_q  <= rcd_d;
      ras_q  <= ras_d;
      rc_q   <= rc_d;
      rp_q   <= rp_d;
      rec_q  <= rec_d;
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign col_ok_o = open_q && !ap_q && (rcd_q == '0);
  assign pre_ok_o = !open_q || (!ap_q && (ras_q == '0) && (rec_q == '0));
  assign act_ok_o = !open_q && (rp_q == '0) && (rc_q == '0);

  // R3
  rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> (open_q && rcd_q == '0));
  // R4
  ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && open_q) |-> (ras_q == '0));
  // R6
  recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && open_q) |-> (rec_q == '0));
  // R4
  act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && rp_q == '0 && rc_q == '0));
  // R9
  ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_q && rec_q == '0 && ras_q == '0) |=> !open_q);

endmodule

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic served_i,
  output logic pend_o
);

  localparam int W = $clog2(INTERVAL + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         pend_q, pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (served_i) pend_d = 1'b0;
    if (!en_i) begin
      cnt_d = W'(INTERVAL - 1);
    end else if (cnt_q == '0) begin
      cnt_d  = W'(INTERVAL - 1);
      pend_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= W'(INTERVAL - 1);
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !served_i) |=> pend_q);

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int NBANK        = 4,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 9,
  parameter int ADDR_W       = 13,
  parameter int CLK_PS       = 10000,
  parameter int T_RCD_NS     = 18,
  parameter int T_RAS_NS     = 42,
  parameter int T_RP_NS      = 18,
  parameter int T_RC_NS      = 60,
  parameter int T_RRD_NS     = 12,
  parameter int T_WR         = 2,
  parameter int BURST_LEN    = 4,
  parameter int INIT_CYC     = 20000,
  parameter int REF_INTERVAL = 780,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
  localparam int BANK_W      = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  output logic              req_grant,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);

  localparam int T_RCD  = ns2clk(T_RCD_NS, CLK_PS);
  localparam int T_RAS  = ns2clk(T_RAS_NS, CLK_PS);
  localparam int T_RP   = ns2clk(T_RP_NS, CLK_PS);
  localparam int T_RC   = ns2clk(T_RC_NS, CLK_PS);
  localparam int T_RRD  = ns2clk(T_RRD_NS, CLK_PS);
  localparam int CW     = $clog2(T_RC + T_RAS + T_RRD + BURST_LEN + T_WR + 2);
  localparam int WAIT_W = $clog2(INIT_CYC + 1);
  localparam int AP_BIT = 10;

  phase_e              phase_q, phase_d;
  cmd_e                cmd_q, cmd_d;
  logic [BANK_W-1:0]   ba_q, ba_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [WAIT_W-1:0]   wait_q, wait_d;
  logic [CW-1:0]       rrd_q, rrd_d, burst_q, burst_d;
  logic [NBANK-1:0]    act_v, pre_v, col_v, b_open, b_colok, b_preok, b_actok;
  logic [ROW_W-1:0]    b_row [NBANK];
  logic                ref_b, served, ref_pend, hit, any_open, all_preok, all_actok;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    bank_track #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC),
      .T_WR(T_WR), .BL(BURST_LEN), .ROW_W(ROW_W), .CW(CW)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(act_v[g]), .ref_i(ref_b), .pre_i(pre_v[g]), .col_i(col_v[g]),
      .wr_i(req_write), .ap_i(req_ap), .row_i(req_row),
      .open_o(b_open[g]), .row_o(b_row[g]), .col_ok_o(b_colok[g]),
      .pre_ok_o(b_preok[g]), .act_ok_o(b_actok[g])
    );
  end

  ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .en_i(phase_q == ST_RUN),
    .served_i(served), .pend_o(ref_pend)
  );

  assign any_open  = |b_open;
  assign all_preok = &b_preok;
  assign all_actok = &b_actok;
  assign hit       = b_open[req_bank] && (b_row[req_bank] == req_row);

  always_comb begin
    phase_d   = phase_q;
    wait_d    = (wait_q  == '0) ? wait_q  : wait_q  - 1'b1;
    rrd_d     = (rrd_q   == '0) ? rrd_q   : rrd_q   - 1'b1;
    burst_d   = (burst_q == '0) ? burst_q : burst_q - 1'b1;
    cmd_d     = C_NOP;
    ba_d      = '0;
    addr_d    = '0;
    act_v     = '0;
    pre_v     = '0;
    col_v     = '0;
    ref_b     = 1'b0;
    served    = 1'b0;
    req_grant = 1'b0;
    unique case (phase_q)
      ST_WAIT: if (wait_q == '0) phase_d = ST_PREALL;
      ST_PREALL: begin
        cmd_d          = C_PRE;
        addr_d[AP_BIT] = 1'b1;
        pre_v          = '1;
        phase_d        = ST_REF1;
      end
      ST_REF1, ST_REF2: if (all_actok) begin
        cmd_d   = C_REF;
        ref_b   = 1'b1;
        phase_d = (phase_q == ST_REF1) ? ST_REF2 : ST_MRS;
      end
      ST_MRS: if (all_actok) begin
        cmd_d   = C_MRS;
        addr_d  = MODE_WORD;
        phase_d = ST_RUN;
      end
      default: begin
        if (ref_pend) begin
          if (burst_q == '0) begin
            if (any_open) begin
              if (all_preok) begin
                cmd_d          = C_PRE;
                addr_d[AP_BIT] = 1'b1;
                pre_v          = '1;
              end
            end else if (all_actok) begin
              cmd_d  = C_REF;
              ref_b  = 1'b1;
              served = 1'b1;
            end
          end
        end else if (req_valid) begin
          if (hit) begin
            if (b_colok[req_bank] && burst_q == '0) begin
              cmd_d              = req_write ? C_WR : C_RD;
              ba_d               = req_bank;
              addr_d[COL_W-1:0]  = req_col;
              addr_d[AP_BIT]     = req_ap;
              col_v[req_bank]    = 1'b1;
              req_grant          = 1'b1;
              burst_d            = CW'(BURST_LEN - 1);
            end
          end else if (b_open[req_bank]) begin
            if (b_preok[req_bank]) begin
              cmd_d           = C_PRE;
              ba_d            = req_bank;
              pre_v[req_bank] = 1'b1;
            end
          end else if (b_actok[req_bank] && rrd_q == '0) begin
            cmd_d             = C_ACT;
            ba_d              = req_bank;
            addr_d[ROW_W-1:0] = req_row;
            act_v[req_bank]   = 1'b1;
            rrd_d             = CW'(T_RRD - 1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_WAIT;
      wait_q  <= WAIT_W'(INIT_CYC - 1);
      rrd_q   <= '0;
      burst_q <= '0;
      cmd_q   <= C_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      wait_q  <= wait_d;
      rrd_q   <= rrd_d;
      burst_q <= burst_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;

  // R1
  init_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_WAIT) |-> (cmd_q == C_NOP));
  // R5
  rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_v) |-> (rrd_q == '0));
  // R10
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_b |-> !any_open);
  // R7
  grant_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |=> (!sd_cs_n && sd_ras_n && !sd_cas_n));

endmodule

// File: tb/tb_sdram_seq.sv
`timescale 1ns/1ps
module tb_sdram_seq;

  localparam int CLK_PS = 10000;
  localparam int INIT   = 40;
  localparam int RINT   = 150;
  localparam int SLACK  = 40;
  localparam int BL     = 4;
  localparam int TWR    = 2;
  // R11: independent ceiling conversion of the ns limits
  localparam int TRCD = (18000 + CLK_PS - 1) / CLK_PS;
  localparam int TRAS = (42000 + CLK_PS - 1) / CLK_PS;
  localparam int TRP  = (18000 + CLK_PS - 1) / CLK_PS;
  localparam int TRC  = (60000 + CLK_PS - 1) / CLK_PS;
  localparam int TRRD = (12000 + CLK_PS - 1) / CLK_PS;

  typedef struct packed {
    logic        w;
    logic [1:0]  b;
    logic [12:0] row;
    logic [8:0]  col;
    logic        ap;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [8:0]  req_col = '0;
  logic req_grant, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;

  always #5 clk = ~clk;

  sdram_seq #(.INIT_CYC(INIT), .REF_INTERVAL(RINT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ap(req_ap),
    .req_grant(req_grant), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  int n_chk = 0, n_fail = 0, t = 0, n_sent = 0, n_col = 0;
  int init_idx = 0, run_refs = 0, refmark = 0;
  int last_act[4], close_t[4], last_rd[4], last_wr[4], ap_close[4], row_m[4];
  bit open_m[4], ap_pend[4];
  int last_act_any = -1000, last_ref = -1000, last_col = -1000;
  bit done = 1'b0;
  item_t exp_q[$];

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) t <= t + 1;

  // monitor: decode the pins, check timing, pop the scoreboard on column commands
  initial begin
    for (int b = 0; b < 4; b++) begin
      last_act[b] = -1000; close_t[b] = -1000; last_rd[b] = -1000;
      last_wr[b] = -1000; open_m[b] = 0; ap_pend[b] = 0; row_m[b] = 0;
    end
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      begin
        logic [3:0] c;
        int b;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        b = int'(sd_ba);
        for (int k = 0; k < 4; k++)
          if (ap_pend[k] && t >= ap_close[k]) begin
            open_m[k] = 0; close_t[k] = ap_close[k]; ap_pend[k] = 0;
          end
        if (init_idx < 4 && c != 4'b0111) begin
          if (init_idx == 0) chk(t >= INIT, "R1 first command after wait", t, INIT);
          case (init_idx)
            0: chk(c == 4'b0010 && sd_addr[10], "R2 init precharge-all", c, 2);
            1, 2: chk(c == 4'b0001, "R2 init refresh", c, 1);
            default: begin
              chk(c == 4'b0000, "R2 init mode code", c, 0);
              chk(sd_addr == 13'h032, "R2 mode word", sd_addr, 'h32);
              refmark = t;
            end
          endcase
          if (c == 4'b0001) last_ref = t;
          init_idx++;
        end else if (c == 4'b0011) begin
          chk(!open_m[b], "R4 activate on closed bank", open_m[b], 0);
          chk(t - close_t[b] >= TRP, "R4 close->activate", t - close_t[b], TRP);
          chk(t - last_act[b] >= TRC, "R4 activate->activate same bank", t - last_act[b], TRC);
          chk(t - last_ref >= TRC, "R4 refresh->activate", t - last_ref, TRC);
          chk(t - last_act_any >= TRRD, "R5 activate spacing", t - last_act_any, TRRD);
          chk(exp_q.size() > 0 && exp_q[0].b == sd_ba && exp_q[0].row == sd_addr,
              "R8 activate targets pending row", sd_addr, exp_q.size() > 0 ? exp_q[0].row : -1);
          open_m[b] = 1; row_m[b] = sd_addr; last_act[b] = t; last_act_any = t;
        end else if (c == 4'b0101 || c == 4'b0100) begin
          item_t it;
          n_col++;
          chk(exp_q.size() > 0, "R7 unexpected column command", exp_q.size(), 1);
          if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            chk(sd_ba == it.b && sd_addr[8:0] == it.col && (c == 4'b0100) == it.w
                && sd_addr[10] == it.ap, "R7 column command fields", sd_addr, {it.ap, 1'b0, it.col});
            chk(open_m[b] && row_m[b] == it.row, "R3 R8 bank open on requested row", row_m[b], it.row);
          end
          chk(t - last_act[b] >= TRCD, "R3 R11 activate->column", t - last_act[b], TRCD);
          chk(t - last_col >= BL, "R7 column spacing", t - last_col, BL);
          last_col = t;
          if (c == 4'b0100) last_wr[b] = t; else last_rd[b] = t;
          if (sd_addr[10]) begin
            int ce;
            ce = (c == 4'b0100) ? t + BL - 1 + TWR : t + BL;
            if (last_act[b] + TRAS > ce) ce = last_act[b] + TRAS;
            ap_pend[b] = 1; ap_close[b] = ce;
          end
        end else if (c == 4'b0010) begin
          for (int k = 0; k < 4; k++)
            if ((sd_addr[10] || k == b) && open_m[k]) begin
              chk(!ap_pend[k], "R9 no precharge while auto-close pending", ap_pend[k], 0);
              chk(t - last_act[k] >= TRAS, "R4 activate->precharge", t - last_act[k], TRAS);
              chk(t - last_wr[k] >= BL - 1 + TWR, "R6 write recovery", t - last_wr[k], BL - 1 + TWR);
              chk(t - last_rd[k] >= BL, "R6 read->precharge", t - last_rd[k], BL);
              open_m[k] = 0; close_t[k] = t;
            end
          if (!sd_addr[10])
            chk(exp_q.size() > 0 && exp_q[0].b == sd_ba && row_m[b] != int'(exp_q[0].row),
                "R8 single precharge only on row miss", row_m[b], exp_q.size() > 0 ? exp_q[0].row : -1);
        end else if (c == 4'b0001) begin
          for (int k = 0; k < 4; k++) begin
            chk(!open_m[k], "R10 refresh with all banks closed", open_m[k], 0);
            chk(t - close_t[k] >= TRP, "R10 close->refresh", t - close_t[k], TRP);
            chk(t - last_act[k] >= TRC, "R10 activate->refresh", t - last_act[k], TRC);
          end
          chk(t - last_ref >= TRC, "R10 refresh spacing", t - last_ref, TRC);
          chk(t - refmark <= RINT + SLACK, "R10 refresh interval", t - refmark, RINT + SLACK);
          last_ref = t; refmark = t; run_refs++;
        end else if (c != 4'b0111) begin
          chk(1'b0, "R7 illegal command code", c, 7);
        end
      end
    end
  end

  // driver: push the expected column command, then hold the request until granted
  task automatic send(input bit w, input int b, input int row, input int col, input bit ap);
    item_t it;
    bit g;
    it.w = w; it.b = 2'(b); it.row = 13'(row); it.col = 9'(col); it.ap = ap;
    exp_q.push_back(it);
    n_sent++;
    req_write = w; req_bank = 2'(b); req_row = 13'(row); req_col = 9'(col); req_ap = ap;
    req_valid = 1'b1;
    g = 1'b0;
    while (!g) begin
      #1;
      g = req_grant;
      if (!g) @(negedge clk);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle code while reset is held
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 reset idle",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
    rst_n = 1'b1;
    wait (init_idx == 4);
    @(negedge clk);
    send(1, 0, 5, 8, 0);    // closed bank: activate then write
    send(0, 0, 5, 16, 0);   // R8 row hit
    send(1, 1, 7, 0, 0);    // R5 second bank
    send(0, 0, 9, 4, 0);    // R8 row miss
    send(1, 2, 1, 2, 1);    // R9 write with auto-close
    send(0, 2, 1, 3, 1);    // R9 reopen after auto-close, read
    send(0, 3, 2, 5, 1);
    send(1, 3, 3, 6, 0);
    for (int i = 0; i < 40; i++)
      send(i % 3 == 0, i % 4, (i % 7 < 3) ? 5 : i % 5, (i * 8) % 512, i % 5 == 4);
    repeat (500) @(negedge clk);
    chk(exp_q.size() == 0, "R7 every request served", exp_q.size(), 0);
    chk(n_col == n_sent, "R7 one column command per request", n_col, n_sent);
    chk(run_refs >= 3, "R10 periodic refresh", run_refs, 3);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

endmodule